// File: doc/BRIEF.md
# Predictive phased pseudo-associative data cache

This block is a read-path data cache made of four direct-mapped ways. It saves array energy by enabling only the arrays it needs in each cycle. A way predictor sits in front of the arrays. It holds one 2-bit way number for each of 1024 entries and is indexed by bits [11:2] of the instruction address. The prediction is looked up when a request is accepted. The first access cycle then enables the tag and data arrays of that one predicted way.

If the predicted probe misses, a fallback phase follows. In the next cycle the block reads only the tags of the three remaining ways. If one of them matches, the cycle after that reads only that way's data. If none matches, the block asks the next level for the word, writes it into a victim way chosen by pseudo-LRU and returns it. Each response carries the number of cycles it took, counted from the first access cycle. The per-cycle tag and data enables are brought out as ports so that array activity can be observed.

The controller has five states:
- S_IDLE waits for a request and moves to S_PROBE on accept.
- S_PROBE returns to S_IDLE on a predicted hit and otherwise goes to S_TAGS.
- S_TAGS goes to S_DATA on a hit in another way and otherwise to S_FILL.
- S_DATA always returns to S_IDLE.
- S_FILL stays put until fill data arrives, then returns to S_IDLE.

Top module: `ppc_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid, fill_req, tag_en and data_en are 0, every line is invalid and every predictor entry holds way 0.
- R2: A request is accepted only in S_IDLE when req_valid is 1. req_ready stays 0 from the cycle after acceptance until the response has been issued.
- R3: In the first access cycle only the predicted way's tag and data arrays are enabled. On a hit there, resp_valid rises in the next cycle with resp_cycles = 1.
- R4: After a predicted miss, the next cycle enables only the tags of the three other ways and no data array. On a hit, the following cycle enables only that way's data array, and the response reports resp_cycles = 3.
- R5: If all four tags miss, fill_req is held high with fill_addr equal to the request address until fill_valid. The line is written in the fill_valid cycle, resp_data equals fill_data, and resp_cycles = 3 plus the number of cycles fill_valid came after the first fill_req cycle.
- R6: The victim is the lowest-numbered invalid way of the set. If all ways are valid, it comes from the set's 3-bit tree: b0=0 picks way b1 (0 or 1), and b0=1 picks way 2+b2.
- R7: Every hit and every fill touches the way's tree bits. Touching way w<2 sets b0=1 and b1=(w==0). Touching way w>=2 sets b0=0 and b2=(w==2).
- R8: A fallback hit or a fill writes that way into the predictor entry at PC[11:2]. A predicted hit leaves the entry unchanged. PCs that differ only above bit 11 share an entry.
- R9: At most one data array is enabled in any cycle. Per access the total enables are: 1 tag and 1 data for a predicted hit; 4 tags and 2 data for a fallback hit; 5 tags and 2 data for a miss.
- R10: resp_data on a hit equals the data most recently filled for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Word address to read |
| req_pc | input | ADDR_W | Instruction address used to index the predictor |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | DATA_W | Data read |
| resp_cycles | output | CNT_W | Cycles from first access cycle to completion |
| fill_req | output | 1 | Request to next level |
| fill_addr | output | ADDR_W | Address requested from next level |
| fill_valid | input | 1 | Next-level data present |
| fill_data | input | DATA_W | Next-level data |
| tag_en | output | 4 | Tag arrays enabled this cycle, one bit per way |
| data_en | output | 4 | Data arrays enabled this cycle, one bit per way |

## Verification
The bench keeps a reference model of tags, pseudo-LRU bits and predictor entries, and sums the enable bits over each access. The corner cases it goes after are these:
- A fallback hit that must retrain the predictor. A design that skipped the update would keep paying 3 cycles on the repeat access.
- Two PCs aliasing onto one predictor entry. A design with the wrong index bits would mispredict where the model expects a 1-cycle hit.
- A full set forcing a pseudo-LRU eviction. A wrong touch or victim rule would evict a line the model still holds, and a later access would show up as a miss with the wrong cycle count.
- A design that woke all data arrays in the fallback phase would break the per-access enable totals.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    localparam int unsigned NUM_WAYS = 4;
    localparam int unsigned WAY_W    = $clog2(NUM_WAYS);

    typedef logic [WAY_W-1:0] way_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROBE,
        S_TAGS,
        S_DATA,
        S_FILL
    } state_t;

    function automatic logic [NUM_WAYS-1:0] way_onehot(input way_t w);
        return NUM_WAYS'(1) << w;
    endfunction
endpackage

// File: rtl/ppc_way_pred.sv
module ppc_way_pred
    import ppc_pkg::*;
#(
    parameter int unsigned ENTRIES = 1024,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output way_t             rd_way,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  way_t             upd_way
);
    way_t tbl [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ENTRIES); i++) tbl[i] <= '0;
        end else if (upd_en) begin
            tbl[upd_idx] <= upd_way;
        end
    end

    assign rd_way = tbl[rd_idx];

    // R8
    pred_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> tbl[$past(upd_idx)] == $past(upd_way));
endmodule

// File: rtl/ppc_plru.sv
module ppc_plru
    import ppc_pkg::*;
#(
    parameter int unsigned SETS  = 16,
    parameter int unsigned IDX_W = $clog2(SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    idx,
    input  logic [NUM_WAYS-1:0] valid_vec,
    input  logic                touch_en,
    input  way_t                touch_way,
    output way_t                victim
);
    logic [2:0] bits [SETS];
    logic [2:0] cur;

    assign cur = bits[idx];

    always_comb begin
        if (cur[0] == 1'b0) victim = {1'b0, cur[1]};
        else                victim = {1'b1, cur[2]};
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) victim = way_t'(w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(SETS); i++) bits[i] <= '0;
        end else if (touch_en) begin
            if (!touch_way[1]) begin
                bits[idx][0] <= 1'b1;
                bits[idx][1] <= ~touch_way[0];
            end else begin
                bits[idx][0] <= 1'b0;
                bits[idx][2] <= ~touch_way[0];
            end
        end
    end

    // R7
    plru_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> bits[$past(idx)][0] == !$past(touch_way[1]));
endmodule

// File: rtl/ppc_way_array.sv
module ppc_way_array #(
    parameter int unsigned SETS   = 16,
    parameter int unsigned IDX_W  = $clog2(SETS),
    parameter int unsigned TAG_W  = 26,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic              tag_en,
    input  logic              data_en,
    output logic              hit,
    output logic              valid_o,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [DATA_W-1:0] wr_data
);
    logic              valid [SETS];
    logic [TAG_W-1:0]  tags  [SETS];
    logic [DATA_W-1:0] data  [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(SETS); i++) valid[i] <= 1'b0;
        end else if (we) begin
            valid[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tags[idx] <= tag_in;
            data[idx] <= wr_data;
        end
    end

    assign valid_o = valid[idx];
    assign hit     = tag_en && valid[idx] && (tags[idx] == tag_in);
    assign rdata   = data_en ? data[idx] : '0;

    // R5
    fill_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> valid[$past(idx)] && tags[$past(idx)] == $past(tag_in));
endmodule

// File: rtl/ppc_cache.sv
module ppc_cache
    import ppc_pkg::*;
#(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned SETS         = 16,
    parameter int unsigned PRED_ENTRIES = 1024,
    parameter int unsigned CNT_W        = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [ADDR_W-1:0]   req_pc,
    output logic                req_ready,
    output logic                resp_valid,
    output logic [DATA_W-1:0]   resp_data,
    output logic [CNT_W-1:0]    resp_cycles,
    output logic                fill_req,
    output logic [ADDR_W-1:0]   fill_addr,
    input  logic                fill_valid,
    input  logic [DATA_W-1:0]   fill_data,
    output logic [NUM_WAYS-1:0] tag_en,
    output logic [NUM_WAYS-1:0] data_en
);
    localparam int unsigned OFF_W  = 2;
    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int unsigned PIDX_W = $clog2(PRED_ENTRIES);

    state_t              st, st_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [PIDX_W-1:0]   pidx_q;
    way_t                pred_q, hit_way_q, victim_q;
    logic [CNT_W-1:0]    cnt_q;

    logic [IDX_W-1:0]    idx;
    logic [TAG_W-1:0]    tag;
    logic [NUM_WAYS-1:0] hit_vec, valid_vec, we_vec;
    logic [DATA_W-1:0]   way_rdata [NUM_WAYS];
    logic [DATA_W-1:0]   rdata_or;
    logic                any_hit;
    way_t                hit_way, pred_way, victim;
    logic                accept;
    logic                touch_en, pred_upd;
    way_t                touch_way;
    logic                unused_pc;

    assign idx       = addr_q[OFF_W +: IDX_W];
    assign tag       = addr_q[ADDR_W-1 -: TAG_W];
    assign accept    = (st == S_IDLE) && req_valid;
    assign fill_addr = addr_q;
    assign unused_pc = ^{req_pc[ADDR_W-1:PIDX_W+2], req_pc[1:0]};

    ppc_way_pred #(.ENTRIES(PRED_ENTRIES)) u_pred (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_pc[PIDX_W+1:2]),
        .rd_way  (pred_way),
        .upd_en  (pred_upd),
        .upd_idx (pidx_q),
        .upd_way (touch_way)
    );

    ppc_plru #(.SETS(SETS)) u_plru (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx),
        .valid_vec (valid_vec),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .victim    (victim)
    );

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        ppc_way_array #(
            .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)
        ) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .idx     (idx),
            .tag_in  (tag),
            .tag_en  (tag_en[w]),
            .data_en (data_en[w]),
            .hit     (hit_vec[w]),
            .valid_o (valid_vec[w]),
            .rdata   (way_rdata[w]),
            .we      (we_vec[w]),
            .wr_data (fill_data)
        );
    end

    always_comb begin
        rdata_or = '0;
        hit_way  = '0;
        for (int w = 0; w < int'(NUM_WAYS); w++) begin
            rdata_or = rdata_or | way_rdata[w];
            if (hit_vec[w]) hit_way = way_t'(w);
        end
    end
    assign any_hit = |hit_vec;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_d;
    end

    // Outputs and next state
    always_comb begin
        st_d      = st;
        req_ready = 1'b0;
        tag_en    = '0;
        data_en   = '0;
        we_vec    = '0;
        fill_req  = 1'b0;
        touch_en  = 1'b0;
        touch_way = pred_q;
        pred_upd  = 1'b0;
        unique case (st)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) st_d = S_PROBE;
            end
            S_PROBE: begin
                tag_en  = way_onehot(pred_q);
                data_en = way_onehot(pred_q);
                if (any_hit) begin
                    touch_en = 1'b1;
                    st_d     = S_IDLE;
                end else begin
                    st_d = S_TAGS;
                end
            end
            S_TAGS: begin
                tag_en = ~way_onehot(pred_q);
                st_d   = any_hit ? S_DATA : S_FILL;
            end
            S_DATA: begin
                data_en   = way_onehot(hit_way_q);
                touch_en  = 1'b1;
                touch_way = hit_way_q;
                pred_upd  = 1'b1;
                st_d      = S_IDLE;
            end
            S_FILL: begin
                fill_req  = 1'b1;
                touch_way = victim_q;
                if (fill_valid) begin
                    tag_en   = way_onehot(victim_q);
                    data_en  = way_onehot(victim_q);
                    we_vec   = way_onehot(victim_q);
                    touch_en = 1'b1;
                    pred_upd = 1'b1;
                    st_d     = S_IDLE;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // Request, phase and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            pidx_q      <= '0;
            pred_q      <= '0;
            hit_way_q   <= '0;
            victim_q    <= '0;
            cnt_q       <= '0;
            resp_valid  <= 1'b0;
            resp_data   <= '0;
            resp_cycles <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (accept) begin
                addr_q <= req_addr;
                pidx_q <= req_pc[PIDX_W+1:2];
                pred_q <= pred_way;
                cnt_q  <= CNT_W'(1);
            end else if (st != S_IDLE && cnt_q != '1) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (st == S_TAGS) begin
                hit_way_q <= hit_way;
                victim_q  <= victim;
            end
            if ((st == S_PROBE && any_hit) || st == S_DATA) begin
                resp_valid  <= 1'b1;
                resp_data   <= rdata_or;
                resp_cycles <= cnt_q;
            end
            if (st == S_FILL && fill_valid) begin
                resp_valid  <= 1'b1;
                resp_data   <= fill_data;
                resp_cycles <= cnt_q;
            end
        end
    end

    // R9
    data_en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_en));

    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R5
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && !fill_valid |=> fill_req && $stable(fill_addr));

    // R3
    fast_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_cycles == CNT_W'(1) |-> $past(st) == S_PROBE);
endmodule

// File: tb/ppc_cache_tb.sv
module ppc_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int SETS       = 16;
    localparam int IDX_W      = $clog2(SETS);
    localparam int TAG_W      = ADDR_W - 2 - IDX_W;
    localparam int PENT       = 1024;
    localparam int FILL_LAT   = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr, req_pc;
    logic              req_ready, resp_valid, fill_req, fill_valid;
    logic [DATA_W-1:0] resp_data, fill_data;
    logic [3:0]        resp_cycles, tag_en, data_en;
    logic [ADDR_W-1:0] fill_addr;

    ppc_cache u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_pc(req_pc), .req_ready(req_ready), .resp_valid(resp_valid),
        .resp_data(resp_data), .resp_cycles(resp_cycles), .fill_req(fill_req),
        .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data),
        .tag_en(tag_en), .data_en(data_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int n_resp = 0;

    logic [TAG_W-1:0]  m_tag  [SETS][4];
    bit                m_val  [SETS][4];
    logic [DATA_W-1:0] m_data [SETS][4];
    bit   [2:0]        m_plru [SETS];
    bit   [1:0]        m_pred [PENT];

    logic [DATA_W-1:0] q_data [$];
    int                q_cyc  [$];
    int                q_tags [$];
    int                q_dats [$];
    string             q_lbl  [$];
    int acc_tags = 0;
    int acc_dats = 0;

    function automatic logic [DATA_W-1:0] fill_fn(input logic [ADDR_W-1:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string lbl,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
        end
    endtask

    // R7 model of the tree touch
    task automatic m_touch(input int s, input int w);
        if (w < 2) begin
            m_plru[s][0] = 1'b1;
            m_plru[s][1] = (w == 0);
        end else begin
            m_plru[s][0] = 1'b0;
            m_plru[s][2] = (w == 2);
        end
    endtask

    // R6 model of the victim choice
    function automatic int m_victim(input int s);
        for (int w = 0; w < 4; w++) if (!m_val[s][w]) return w;
        if (m_plru[s][0] == 1'b0) return int'(m_plru[s][1]);
        return 2 + int'(m_plru[s][2]);
    endfunction

    task automatic access(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] pc,
                          input string lbl);
        int s, p, hw, cyc, tg, dt, target;
        logic [TAG_W-1:0]  t;
        logic [DATA_W-1:0] d;
        s  = int'(a[2 +: IDX_W]);
        t  = a[ADDR_W-1 -: TAG_W];
        p  = int'(m_pred[pc[11:2]]);
        hw = -1;
        if (m_val[s][p] && m_tag[s][p] == t) begin
            cyc = 1; tg = 1; dt = 1; d = m_data[s][p];
            m_touch(s, p);
        end else begin
            for (int w = 0; w < 4; w++)
                if (w != p && m_val[s][w] && m_tag[s][w] == t) hw = w;
            if (hw >= 0) begin
                cyc = 3; tg = 4; dt = 2; d = m_data[s][hw];
            end else begin
                hw  = m_victim(s);
                cyc = 3 + FILL_LAT; tg = 5; dt = 2; d = fill_fn(a);
                m_val[s][hw] = 1'b1; m_tag[s][hw] = t; m_data[s][hw] = d;
            end
            m_touch(s, hw);
            m_pred[pc[11:2]] = 2'(hw);
        end
        q_data.push_back(d); q_cyc.push_back(cyc);
        q_tags.push_back(tg); q_dats.push_back(dt); q_lbl.push_back(lbl);
        target = n_resp + 1;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_pc = pc;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2 ready low while busy", 32'(req_ready), 0);
        while (n_resp != target) @(negedge clk);
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int tg, input int s);
        return ADDR_W'((tg << (IDX_W + 2)) | (s << 2));
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (resp_valid) begin
                if (q_data.size() == 0) begin
                    chk(1'b0, "R2 unexpected response", 1, 0);
                end else begin
                    logic [DATA_W-1:0] ed;
                    int ec, et, edt;
                    string l;
                    ed = q_data.pop_front(); ec = q_cyc.pop_front();
                    et = q_tags.pop_front(); edt = q_dats.pop_front();
                    l = q_lbl.pop_front();
                    chk(resp_data === ed, {l, " R10 data"}, resp_data, ed);
                    chk(int'(resp_cycles) == ec, {l, " cycles"}, 32'(resp_cycles), 32'(ec));
                    chk(acc_tags == et, {l, " R9 tag enables"}, 32'(acc_tags), 32'(et));
                    chk(acc_dats == edt, {l, " R9 data enables"}, 32'(acc_dats), 32'(edt));
                end
                n_resp++;
                acc_tags = 0;
                acc_dats = 0;
            end
            acc_tags += $countones(tag_en);
            acc_dats += $countones(data_en);
        end
    end

    // Next-level responder
    initial begin
        fill_valid = 1'b0;
        fill_data  = '0;
        forever begin
            @(negedge clk);
            if (rst_n && fill_req && !fill_valid) begin
                repeat (FILL_LAT) @(negedge clk);
                fill_valid = 1'b1;
                fill_data  = fill_fn(fill_addr);
                @(negedge clk);
                fill_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog expired actual=hang expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] pa, pb;
        pa = 32'h0000_0100;
        pb = 32'h0000_0204;
        for (int s = 0; s < SETS; s++) begin
            m_plru[s] = '0;
            for (int w = 0; w < 4; w++) m_val[s][w] = 1'b0;
        end
        for (int i = 0; i < PENT; i++) m_pred[i] = '0;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_pc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 1);
        chk({resp_valid, fill_req} == 2'b00, "R1 reset strobes", 32'({resp_valid, fill_req}), 0);
        chk({tag_en, data_en} == 8'h00, "R1 reset enables", 32'({tag_en, data_en}), 0);

        access(mk(1, 0), pa, "R5 cold miss");
        access(mk(1, 0), pa, "R3 predicted hit");
        access(mk(2, 0), pb, "R6 second invalid way");
        access(mk(1, 0), pb, "R4 fallback hit");
        access(mk(1, 0), pb, "R8 retrained hit");
        access(mk(3, 0), pa, "R6 third way");
        access(mk(4, 0), pa, "R6 fourth way");
        access(mk(5, 0), pa, "R7 tree eviction");
        access(mk(5, 0), pa + 32'h1000, "R8 aliased pc");
        access(mk(1, 3), pb, "R6 other set");
        for (int i = 0; i < 48; i++) begin
            access(mk((i * 7) % 6 + 1, i % 3), 32'(i % 5) << 2, "R7 mixed");
        end

        repeat (3) @(negedge clk);
        chk(q_data.size() == 0, "R2 all responses", 32'(q_data.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule